// File: doc/BRIEF.md
# Early-Lookup Address Generator

This block sits in the address-generation stage of a load/store pipeline. It adds a 32-bit base register value to a 16-bit signed immediate and produces the virtual address. In the same cycle it decides whether the cache tag arrays and the translation buffer can be looked up one stage early. For that early lookup it uses the base value's own set and page fields, which it passes straight through.

The early lookup is only offered when the immediate is small: the value 0, a positive value up to 15, or a negative value down to -16. For such offsets a carry can only disturb the set or page field in rare cases. Two flags report when the real address has left the set or the page that was looked up early. Each flag comes from a carry taken out of the middle of the adder, not from a comparison of full addresses. When a flag is set, the following stage repeats the lookup with the real address.

All outputs are combinational and valid in the cycle the inputs are presented. The block stores nothing, so it has no back-pressure: the consumer samples the outputs on the same edge that accepts the load request.

Top module: `spec_addr_gen`

## Requirements
- R1: `addr_o` equals `base_i` plus `imm_i` sign-extended to 32 bits, modulo 2^32, for every input value.
- R2: `early_set_o` always equals `base_i[11:5]` and `early_page_o` always equals `base_i[31:12]`, whatever the immediate or `ld_valid_i`.
- R3: `early_en_o` is 1 exactly when `ld_valid_i` is 1 and `imm_i`, read as a signed number, lies in the range -16 to 15 (its bits 15:4 are all 0 or all 1).
- R4: While `ld_valid_i` is 0, `early_en_o`, `set_miss_o` and `page_miss_o` are all 0.
- R5: For an immediate outside -16..15, `early_en_o`, `set_miss_o` and `page_miss_o` are 0 even when the real address crosses into another set or page.
- R6: `set_miss_o` is 1 exactly when `early_en_o` is 1 and `addr_o[11:5]` differs from `base_i[11:5]`, for positive and negative immediates alike.
- R7: `page_miss_o` is 1 exactly when `early_en_o` is 1 and `addr_o[31:12]` differs from `base_i[31:12]`.
- R8: `page_miss_o` is never 1 while `set_miss_o` is 0.
- R9: A zero immediate with `ld_valid_i` at 1 gives `early_en_o` 1 and both miss flags 0 for any base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| base_i | input | 32 | Base register value |
| imm_i | input | 16 | Signed immediate offset |
| ld_valid_i | input | 1 | A load request is present this cycle |
| addr_o | output | 32 | Computed virtual address |
| early_en_o | output | 1 | Early tag and translation lookup may be used |
| early_set_o | output | 7 | Set index used for the early tag lookup |
| early_page_o | output | 20 | Page number used for the early translation lookup |
| set_miss_o | output | 1 | Real address lies in a different set than the early lookup |
| page_miss_o | output | 1 | Real address lies in a different page than the early lookup |

## Verification
The hardest case to reach is a page miss, which needs a base whose set field is all ones with an offset that carries out of the line, or a set field of zero with a negative offset that borrows. The bench crosses every line offset value with set fields of zero, all ones and a middle value, and page fields at both extremes and a middle value, and sweeps every immediate from -40 to 40 over those bases. This reaches both carry and borrow crossings at the set and page boundaries, and it also reaches out-of-range immediates that would cross but must stay silent. Expected flags come from comparing the fields of the arithmetically computed address with those of the base.

// File: rtl/spec_agu_pkg.sv
package spec_agu_pkg;

  typedef enum logic [1:0] {
    OFS_ZERO = 2'd0,
    OFS_POS  = 2'd1,
    OFS_NEG  = 2'd2,
    OFS_WIDE = 2'd3
  } ofs_class_e;

endpackage

// File: rtl/imm_classifier.sv
module imm_classifier
  import spec_agu_pkg::*;
#(
  parameter int IMM_W    = 16,
  parameter int NARROW_W = 4
) (
  input  logic [IMM_W-1:0] imm_i,
  output ofs_class_e       cls_o
);
  localparam int HI_W = IMM_W - NARROW_W;

  logic [HI_W-1:0] hi_bits;
  logic            hi_ones;
  logic            hi_zeros;
  logic            lo_zeros;

  assign hi_bits  = imm_i[IMM_W-1:NARROW_W];
  assign hi_ones  = &hi_bits;
  assign hi_zeros = ~|hi_bits;
  assign lo_zeros = ~|imm_i[NARROW_W-1:0];

  always_comb begin
    if (hi_ones)               cls_o = OFS_NEG;
    else if (hi_zeros && lo_zeros) cls_o = OFS_ZERO;
    else if (hi_zeros)         cls_o = OFS_POS;
    else                       cls_o = OFS_WIDE;
  end

  always_comb begin
    assert_narrow_in_range_R3: assert ((cls_o == OFS_WIDE) ==
      ((int'($signed(imm_i)) < -(2 ** NARROW_W)) ||
       (int'($signed(imm_i)) > (2 ** NARROW_W) - 1)))
      else $error("narrow class disagrees with signed range");
  end

endmodule

// File: rtl/seg_carry_adder.sv
module seg_carry_adder #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 7
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic [ADDR_W-1:0] sum_o,
  output logic              c_off_o,
  output logic              c_idx_o
);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int NSEG  = 3;

  logic [NSEG:0] carry;
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int LO = (g == 0) ? 0 : ((g == 1) ? OFF_W : OFF_W + IDX_W);
    localparam int W  = (g == 0) ? OFF_W : ((g == 1) ? IDX_W : TAG_W);
    logic [W:0] part;
    assign part = {1'b0, a_i[LO +: W]} + {1'b0, b_i[LO +: W]} + {{W{1'b0}}, carry[g]};
    assign sum_o[LO +: W] = part[W-1:0];
    assign carry[g+1] = part[W];
  end

  assign c_off_o = carry[1];
  assign c_idx_o = carry[2];

endmodule

// File: rtl/miss_detector.sv
module miss_detector (
  input  logic en_i,
  input  logic neg_i,
  input  logic c_off_i,
  input  logic c_idx_i,
  output logic set_miss_o,
  output logic page_miss_o
);
  // A negative offset adds all ones above the line offset; the field keeps its
  // value only when the incoming carry cancels that, so a miss is the inverted carry.
  assign set_miss_o  = en_i & (c_off_i ^ neg_i);
  assign page_miss_o = en_i & (c_idx_i ^ neg_i);

  always_comb begin
    assert_page_implies_set_R8: assert (!page_miss_o || set_miss_o)
      else $error("page miss without set miss");
  end

endmodule

// File: rtl/spec_addr_gen.sv
module spec_addr_gen
  import spec_agu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 16,
  parameter int OFF_W    = 5,
  parameter int IDX_W    = 7,
  parameter int NARROW_W = 4
) (
  input  logic [ADDR_W-1:0]              base_i,
  input  logic [IMM_W-1:0]               imm_i,
  input  logic                           ld_valid_i,
  output logic [ADDR_W-1:0]              addr_o,
  output logic                           early_en_o,
  output logic [IDX_W-1:0]               early_set_o,
  output logic [ADDR_W-OFF_W-IDX_W-1:0]  early_page_o,
  output logic                           set_miss_o,
  output logic                           page_miss_o
);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int EXT_W = ADDR_W - IMM_W;

  ofs_class_e        cls;
  logic [ADDR_W-1:0] imm_ext;
  logic              c_off;
  logic              c_idx;

  imm_classifier #(
    .IMM_W    (IMM_W),
    .NARROW_W (NARROW_W)
  ) u_cls (
    .imm_i (imm_i),
    .cls_o (cls)
  );

  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  seg_carry_adder #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W)
  ) u_add (
    .a_i     (base_i),
    .b_i     (imm_ext),
    .sum_o   (addr_o),
    .c_off_o (c_off),
    .c_idx_o (c_idx)
  );

  assign early_en_o   = ld_valid_i & (cls != OFS_WIDE);
  assign early_set_o  = base_i[OFF_W +: IDX_W];
  assign early_page_o = base_i[ADDR_W-1 -: TAG_W];

  miss_detector u_miss (
    .en_i        (early_en_o),
    .neg_i       (cls == OFS_NEG),
    .c_off_i     (c_off),
    .c_idx_i     (c_idx),
    .set_miss_o  (set_miss_o),
    .page_miss_o (page_miss_o)
  );

  always_comb begin
    assert_sum_R1: assert (addr_o == base_i + imm_ext)
      else $error("address sum wrong");
    assert_idle_quiet_R4: assert (ld_valid_i || (!early_en_o && !set_miss_o && !page_miss_o))
      else $error("activity without load");
    assert_set_hit_R6: assert (!early_en_o || set_miss_o || (addr_o[OFF_W +: IDX_W] == early_set_o))
      else $error("set changed without miss flag");
    assert_page_hit_R7: assert (!early_en_o || page_miss_o || (addr_o[ADDR_W-1 -: TAG_W] == early_page_o))
      else $error("page changed without miss flag");
  end

endmodule

// File: tb/spec_addr_gen_tb.sv
module spec_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] imm_i = '0;
  logic        ld_valid_i = 1'b0;
  logic [31:0] addr_o;
  logic        early_en_o;
  logic [6:0]  early_set_o;
  logic [19:0] early_page_o;
  logic        set_miss_o;
  logic        page_miss_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_addr_gen dut_i (
    .base_i       (base_i),
    .imm_i        (imm_i),
    .ld_valid_i   (ld_valid_i),
    .addr_o       (addr_o),
    .early_en_o   (early_en_o),
    .early_set_o  (early_set_o),
    .early_page_o (early_page_o),
    .set_miss_o   (set_miss_o),
    .page_miss_o  (page_miss_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s base=%h imm=%h vld=%0b actual=%h expected=%h",
               req, base_i, imm_i, ld_valid_i, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] b, input logic [15:0] im, input logic v);
    logic [31:0] ea;
    logic        nar;
    logic        en;
    @(posedge clk);
    base_i = b; imm_i = im; ld_valid_i = v;
    @(negedge clk);
    ea  = b + {{16{im[15]}}, im};
    nar = ($signed(im) >= -16) && ($signed(im) <= 15);
    en  = v && nar;
    chk("R1", addr_o, ea);
    chk("R2_set", 32'(early_set_o), 32'(b[11:5]));
    chk("R2_page", 32'(early_page_o), 32'(b[31:12]));
    chk("R3", 32'(early_en_o), 32'(en));
    chk("R6", 32'(set_miss_o), 32'(en && (ea[11:5] != b[11:5])));
    chk("R7", 32'(page_miss_o), 32'(en && (ea[31:12] != b[31:12])));
    chk("R8", 32'(page_miss_o && !set_miss_o), 32'd0);
    if (!v) chk("R4", {29'd0, early_en_o, set_miss_o, page_miss_o}, 32'd0);
    if (!nar) chk("R5", {29'd0, early_en_o, set_miss_o, page_miss_o}, 32'd0);
    if (v && im == 16'd0) chk("R9", {29'd0, early_en_o, set_miss_o, page_miss_o}, 32'd4);
  endtask

  initial begin
    logic [6:0]  sets [3];
    logic [19:0] pages [3];
    logic [15:0] wide [8];
    sets  = '{7'h00, 7'h7F, 7'h2A};
    pages = '{20'h00000, 20'hFFFFF, 20'h5A3C1};
    wide  = '{16'h0010, 16'hFFEF, 16'h7FFF, 16'h8000, 16'h0020, 16'hFFE0, 16'h1000, 16'hF000};

    // Reset-like state: no load present
    @(negedge clk);
    chk("R4_reset", {29'd0, early_en_o, set_miss_o, page_miss_o}, 32'd0);

    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 3; s++)
        for (int o = 0; o < 32; o++)
          for (int k = -40; k <= 40; k++)
            apply({pages[p], sets[s], o[4:0]}, 16'(k), 1'b1);

    // Wide immediates that cross sets and pages: must stay silent (R5)
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 3; s++)
        for (int w = 0; w < 8; w++)
          apply({pages[p], sets[s], 5'h1F}, wide[w], 1'b1);

    // No load: narrow crossing immediates give no flags (R4)
    for (int o = 0; o < 32; o++)
      for (int k = -16; k <= 15; k++)
        apply({20'hFFFFF, 7'h7F, o[4:0]}, 16'(k), 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule